// File: doc/BRIEF.md
# Descriptor Chain Loader

This block walks a singly linked chain of transfer descriptors in memory and gives each one to a channel's transfer engine. Each descriptor is seven 32-bit words: source address, destination address, link pointer, control-low, control-high, source status and destination status. The block reads the seven words in that order through a word-wide memory request/response port. It keeps at most one access outstanding. When all seven words are in, it presents them to the engine with a one-cycle load pulse.

When the engine reports the block finished, the block writes the engine's updated count/status word back into the descriptor's control-high slot with the done flag set. It then decides whether to follow the link. The link word has two parts. The low two bits choose which bus master fetches the next descriptor. The remaining bits, with the low two bits cleared, give the word-aligned address of the next descriptor. A chain is started by a pulse on `start` with a pointer in the same link format. A one-cycle `chain_done` pulse marks the end of the chain.

Top module: `llchain_loader`

## Requirements
- R1: After reset the block is idle: `busy`, `mem_req`, `blk_load` and `chain_done` are all 0.
- R2: Descriptor words are fetched as reads (`mem_we`=0) at byte offsets 0, 4, 8, 12, 16, 20 and 24 from the descriptor base, in that order. A request holds its address and direction until `mem_rsp_valid`, and the next request starts only after that response.
- R3: For a pointer, bits [1:0] drive `mem_master` for every access to that descriptor. The descriptor base is the pointer with bits [1:0] cleared, so every `mem_addr` has bits [1:0] equal to 0.
- R4: After the seventh response, `blk_load` is high for exactly one cycle with no memory request in that cycle. The six descriptor fields (all words except the link) are on the `blk_*` outputs while it is high.
- R5: After `blk_done`, exactly one write (`mem_we`=1) is issued to base+16 on the descriptor's master. Its data is `blk_status` with bit 12 (the done flag) forced to 1. No other descriptor word is ever written.
- R6: If control-low bit 28 (source chaining) or bit 27 (destination chaining) is set and the link address part is nonzero, the next descriptor is fetched from that address using the link's master bits, after the write-back response.
- R7: A link whose address part is zero ends the chain after the current block. One cycle after the write-back response, `chain_done` pulses for one cycle and `busy` is 0.
- R8: If neither chaining bit is set, the chain ends after the current block whatever the link holds.
- R9: A `start` pulse while `busy` is 1 is ignored: it causes no memory access and does not change the chain being walked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin walking a chain (sampled only when idle) |
| start_ptr | input | ADDR_W | First descriptor pointer, master code in [1:0] |
| busy | output | 1 | A chain is being walked |
| chain_done | output | 1 | One-cycle pulse at the end of the chain |
| mem_req | output | 1 | Memory access request, held until response |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_master | output | 2 | Bus master select for the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_rsp_valid |
| mem_rsp_valid | input | 1 | Response for the pending access |
| blk_load | output | 1 | One-cycle pulse: descriptor fields are valid |
| blk_src_addr | output | 32 | Source address word |
| blk_dst_addr | output | 32 | Destination address word |
| blk_ctl_lo | output | 32 | Control-low word |
| blk_ctl_hi | output | 32 | Control-high word as fetched |
| blk_src_stat | output | 32 | Source status word |
| blk_dst_stat | output | 32 | Destination status word |
| blk_done | input | 1 | Engine reports block finished |
| blk_status | input | 32 | Updated control-high word from the engine |

## Verification
The bench walks a three-descriptor chain. Successive links use different master codes, and each of the two chaining bits is used on its own. The last link has a zero address but nonzero master bits, so a loader that tested the whole word instead of the address part would fetch from address zero. A separate descriptor has both chaining bits clear and a valid-looking link. A loader that ignored the enables would follow it and produce reads the scoreboard does not expect. Response latency is varied so that a loader that moves on before the response, or drops its address early, misorders the scoreboard. A `start` pulse arrives mid-chain; a loader that accepted it would issue extra reads after the chain ends. Every write-back is compared in full, so a wrong offset, a wrong master or a missing done bit shows up as a mismatch.

// File: rtl/llc_pkg.sv
package llc_pkg;
   localparam int unsigned LLC_WORD_W  = 32;
   localparam int unsigned LLC_WORDS   = 7;
   localparam int unsigned LLC_IDX_W   = 3;
   localparam int unsigned LLC_LINK_IX = 2;
   localparam int unsigned LLC_WB_IX   = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_LOAD,
      ST_RUN,
      ST_WBACK
   } llc_state_t;
endpackage

// File: rtl/llc_ptr_decode.sv
module llc_ptr_decode #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned MS_W   = 2
) (
   input  logic [ADDR_W-1:0] ptr,
   output logic [ADDR_W-1:0] base,
   output logic [MS_W-1:0]   master
);
   assign base   = {ptr[ADDR_W-1:MS_W], {MS_W{1'b0}}};
   assign master = ptr[MS_W-1:0];
endmodule

// File: rtl/llc_desc_regs.sv
module llc_desc_regs
   import llc_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cap_en,
   input  logic [LLC_IDX_W-1:0]  cap_idx,
   input  logic [LLC_WORD_W-1:0] cap_data,
   output logic [LLC_WORD_W-1:0] words [LLC_WORDS]
);
   for (genvar g = 0; g < LLC_WORDS; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            words[g] <= '0;
         end else if (cap_en && (cap_idx == LLC_IDX_W'(g))) begin
            words[g] <= cap_data;
         end
      end
   end
endmodule

// File: rtl/llc_sequencer.sv
module llc_sequencer
   import llc_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned MS_W     = 2,
   parameter int unsigned DONE_BIT = 12
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [ADDR_W-1:0]     start_base,
   input  logic [MS_W-1:0]       start_master,
   input  logic [ADDR_W-1:0]     link_base,
   input  logic [MS_W-1:0]       link_master,
   input  logic                  chain_en,
   input  logic                  mem_rsp_valid,
   input  logic                  blk_done,
   input  logic [LLC_WORD_W-1:0] blk_status,
   output logic                  mem_req,
   output logic                  mem_we,
   output logic [ADDR_W-1:0]     mem_addr,
   output logic [MS_W-1:0]       mem_master,
   output logic [LLC_WORD_W-1:0] mem_wdata,
   output logic                  cap_en,
   output logic [LLC_IDX_W-1:0]  cap_idx,
   output logic                  blk_load,
   output logic                  busy,
   output logic                  chain_done
);
   localparam logic [LLC_WORD_W-1:0] DONE_MASK = LLC_WORD_W'(1) << DONE_BIT;
   localparam logic [LLC_IDX_W-1:0]  LAST_IX   = LLC_IDX_W'(LLC_WORDS - 1);
   localparam logic [LLC_IDX_W-1:0]  WB_IX     = LLC_IDX_W'(LLC_WB_IX);

   llc_state_t                state_q;
   logic [ADDR_W-1:0]         base_q;
   logic [MS_W-1:0]           master_q;
   logic [LLC_IDX_W-1:0]      idx_q;
   logic [LLC_WORD_W-1:0]     wb_q;
   logic                      done_q;
   logic [LLC_IDX_W-1:0]      off_idx;
   logic                      follow;

   assign follow  = chain_en && (link_base != '0);
   assign off_idx = (state_q == ST_WBACK) ? WB_IX : idx_q;

   assign mem_req    = (state_q == ST_FETCH) || (state_q == ST_WBACK);
   assign mem_we     = (state_q == ST_WBACK);
   assign mem_addr   = base_q + ADDR_W'({off_idx, 2'b00});
   assign mem_master = master_q;
   assign mem_wdata  = wb_q;
   assign cap_en     = (state_q == ST_FETCH) && mem_rsp_valid;
   assign cap_idx    = idx_q;
   assign blk_load   = (state_q == ST_LOAD);
   assign busy       = (state_q != ST_IDLE);
   assign chain_done = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         base_q   <= '0;
         master_q <= '0;
         idx_q    <= '0;
         wb_q     <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  base_q   <= start_base;
                  master_q <= start_master;
                  idx_q    <= '0;
                  state_q  <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (mem_rsp_valid) begin
                  if (idx_q == LAST_IX) begin
                     state_q <= ST_LOAD;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
            end
            ST_LOAD: begin
               state_q <= ST_RUN;
            end
            ST_RUN: begin
               if (blk_done) begin
                  wb_q    <= blk_status | DONE_MASK;
                  state_q <= ST_WBACK;
               end
            end
            ST_WBACK: begin
               if (mem_rsp_valid) begin
                  if (follow) begin
                     base_q   <= link_base;
                     master_q <= link_master;
                     idx_q    <= '0;
                     state_q  <= ST_FETCH;
                  end else begin
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/llchain_loader.sv
module llchain_loader
   import llc_pkg::*;
#(
   parameter int unsigned ADDR_W        = 32,
   parameter int unsigned MS_W          = 2,
   parameter int unsigned DONE_BIT      = 12,
   parameter int unsigned SRC_CHAIN_BIT = 28,
   parameter int unsigned DST_CHAIN_BIT = 27
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [ADDR_W-1:0]     start_ptr,
   output logic                  busy,
   output logic                  chain_done,
   output logic                  mem_req,
   output logic                  mem_we,
   output logic [ADDR_W-1:0]     mem_addr,
   output logic [MS_W-1:0]       mem_master,
   output logic [LLC_WORD_W-1:0] mem_wdata,
   input  logic [LLC_WORD_W-1:0] mem_rdata,
   input  logic                  mem_rsp_valid,
   output logic                  blk_load,
   output logic [LLC_WORD_W-1:0] blk_src_addr,
   output logic [LLC_WORD_W-1:0] blk_dst_addr,
   output logic [LLC_WORD_W-1:0] blk_ctl_lo,
   output logic [LLC_WORD_W-1:0] blk_ctl_hi,
   output logic [LLC_WORD_W-1:0] blk_src_stat,
   output logic [LLC_WORD_W-1:0] blk_dst_stat,
   input  logic                  blk_done,
   input  logic [LLC_WORD_W-1:0] blk_status
);
   if (ADDR_W != LLC_WORD_W) begin : g_bad_addr
      $error("llchain_loader: ADDR_W must equal the descriptor word width");
   end
   if (MS_W != 2) begin : g_bad_ms
      $error("llchain_loader: master select field is two bits wide");
   end
   if (DONE_BIT >= LLC_WORD_W || SRC_CHAIN_BIT >= LLC_WORD_W || DST_CHAIN_BIT >= LLC_WORD_W) begin : g_bad_bit
      $error("llchain_loader: bit positions must lie inside a word");
   end
   if (SRC_CHAIN_BIT == DST_CHAIN_BIT) begin : g_same_bit
      $error("llchain_loader: chaining enables need distinct bits");
   end

   logic [LLC_WORD_W-1:0] words [LLC_WORDS];
   logic                  cap_en;
   logic [LLC_IDX_W-1:0]  cap_idx;
   logic [ADDR_W-1:0]     start_base;
   logic [MS_W-1:0]       start_master;
   logic [ADDR_W-1:0]     link_base;
   logic [MS_W-1:0]       link_master;
   logic                  chain_en;

   llc_desc_regs u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (cap_en),
      .cap_idx  (cap_idx),
      .cap_data (mem_rdata),
      .words    (words)
   );

   llc_ptr_decode #(.ADDR_W(ADDR_W), .MS_W(MS_W)) u_start_dec (
      .ptr    (start_ptr),
      .base   (start_base),
      .master (start_master)
   );

   llc_ptr_decode #(.ADDR_W(ADDR_W), .MS_W(MS_W)) u_link_dec (
      .ptr    (words[LLC_LINK_IX]),
      .base   (link_base),
      .master (link_master)
   );

   assign chain_en = words[3][SRC_CHAIN_BIT] | words[3][DST_CHAIN_BIT];

   llc_sequencer #(.ADDR_W(ADDR_W), .MS_W(MS_W), .DONE_BIT(DONE_BIT)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .start_base   (start_base),
      .start_master (start_master),
      .link_base    (link_base),
      .link_master  (link_master),
      .chain_en     (chain_en),
      .mem_rsp_valid(mem_rsp_valid),
      .blk_done     (blk_done),
      .blk_status   (blk_status),
      .mem_req      (mem_req),
      .mem_we       (mem_we),
      .mem_addr     (mem_addr),
      .mem_master   (mem_master),
      .mem_wdata    (mem_wdata),
      .cap_en       (cap_en),
      .cap_idx      (cap_idx),
      .blk_load     (blk_load),
      .busy         (busy),
      .chain_done   (chain_done)
   );

   assign blk_src_addr = words[0];
   assign blk_dst_addr = words[1];
   assign blk_ctl_lo   = words[3];
   assign blk_ctl_hi   = words[4];
   assign blk_src_stat = words[5];
   assign blk_dst_stat = words[6];
endmodule

// File: rtl/llc_checker.sv
module llc_checker #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned DONE_BIT = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              chain_done,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [31:0]       mem_wdata,
   input logic              mem_rsp_valid,
   input logic              blk_load
);
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_req && !blk_load));

   a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rsp_valid) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00));

   a_r4_load_single: assert property (@(posedge clk) disable iff (!rst_n)
      blk_load |=> !blk_load);

   a_r4_load_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
      blk_load |-> !mem_req);

   a_r5_done_forced: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> mem_wdata[DONE_BIT]);

   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      chain_done |=> !chain_done);

   a_r7_idle_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      chain_done |-> !busy);
endmodule

bind llchain_loader llc_checker #(.ADDR_W(ADDR_W), .DONE_BIT(DONE_BIT)) u_llc_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy         (busy),
   .chain_done   (chain_done),
   .mem_req      (mem_req),
   .mem_we       (mem_we),
   .mem_addr     (mem_addr),
   .mem_wdata    (mem_wdata),
   .mem_rsp_valid(mem_rsp_valid),
   .blk_load     (blk_load)
);

// File: tb/test_llchain_loader.sv
module test_llchain_loader;
   typedef struct {
      logic        we;
      logic [31:0] addr;
      logic [1:0]  master;
      logic [31:0] wdata;
   } txn_t;

   typedef struct {
      logic [31:0] f [6];
      logic [31:0] status;
   } load_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] start_ptr = '0;
   logic        busy, chain_done, mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [1:0]  mem_master;
   logic [31:0] mem_rdata = '0;
   logic        mem_rsp_valid = 1'b0;
   logic        blk_load;
   logic [31:0] blk_src_addr, blk_dst_addr, blk_ctl_lo, blk_ctl_hi, blk_src_stat, blk_dst_stat;
   logic        blk_done = 1'b0;
   logic [31:0] blk_status = '0;

   int checks = 0;
   int errors = 0;
   int lat = 0;
   int done_pulses = 0;
   logic [31:0] memw [logic [31:0]];
   txn_t  exp_txn [$];
   load_t exp_load [$];

   always #10 clk = ~clk;

   llchain_loader i_llchain_loader (
      .clk(clk), .rst_n(rst_n), .start(start), .start_ptr(start_ptr),
      .busy(busy), .chain_done(chain_done),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_master(mem_master),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rsp_valid(mem_rsp_valid),
      .blk_load(blk_load), .blk_src_addr(blk_src_addr), .blk_dst_addr(blk_dst_addr),
      .blk_ctl_lo(blk_ctl_lo), .blk_ctl_hi(blk_ctl_hi), .blk_src_stat(blk_src_stat),
      .blk_dst_stat(blk_dst_stat), .blk_done(blk_done), .blk_status(blk_status)
   );

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic put_desc(input logic [31:0] base, input logic [31:0] w [7]);
      for (int i = 0; i < 7; i++) memw[base + 32'(4 * i)] = w[i];
   endtask

   // Driver: queue the accesses and the load one descriptor must produce
   task automatic expect_block(input logic [31:0] base, input logic [1:0] ms,
                               input logic [31:0] w [7], input logic [31:0] status);
      txn_t t;
      load_t l;
      for (int i = 0; i < 7; i++) begin
         t.we = 1'b0; t.addr = base + 32'(4 * i); t.master = ms; t.wdata = '0;
         exp_txn.push_back(t);
      end
      l.f[0] = w[0]; l.f[1] = w[1]; l.f[2] = w[3]; l.f[3] = w[4]; l.f[4] = w[5]; l.f[5] = w[6];
      l.status = status;
      exp_load.push_back(l);
      t.we = 1'b1; t.addr = base + 32'd16; t.master = ms; t.wdata = status | 32'h0000_1000;
      exp_txn.push_back(t);
   endtask

   // Memory responder and access monitor (R2, R3, R5, R6)
   initial begin
      int wcnt = 0;
      forever begin
         @(negedge clk);
         if (mem_rsp_valid) begin
            mem_rsp_valid = 1'b0;
         end else if (rst_n && mem_req) begin
            if (wcnt < lat) begin
               wcnt++;
            end else begin
               txn_t e;
               wcnt = 0;
               if (exp_txn.size() == 0) begin
                  check("R9 unexpected access", {mem_we, mem_master, mem_addr}, 0);
               end else begin
                  e = exp_txn.pop_front();
                  if (e.we) check("R5 write-back", {mem_we, mem_master, mem_addr, mem_wdata},
                                  {e.we, e.master, e.addr, e.wdata});
                  else check("R2 R3 R6 fetch", {mem_we, mem_master, mem_addr},
                             {e.we, e.master, e.addr});
               end
               if (mem_we) memw[mem_addr] = mem_wdata;
               else mem_rdata = memw.exists(mem_addr) ? memw[mem_addr] : 32'hDEAD_0000;
               mem_rsp_valid = 1'b1;
            end
         end
      end
   end

   // Engine model and load monitor (R4)
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && blk_load) begin
            load_t l;
            check("R4 no access during load", {127'd0, mem_req}, 0);
            if (exp_load.size() == 0) begin
               check("R4 unexpected load", 1, 0);
            end else begin
               l = exp_load.pop_front();
               check("R4 load fields a", {blk_src_addr, blk_dst_addr, blk_ctl_lo},
                     {l.f[0], l.f[1], l.f[2]});
               check("R4 load fields b", {blk_ctl_hi, blk_src_stat, blk_dst_stat},
                     {l.f[3], l.f[4], l.f[5]});
               @(negedge clk);
               check("R4 load one cycle", {127'd0, blk_load}, 0);
               repeat (2) @(negedge clk);
               blk_status = l.status;
               blk_done = 1'b1;
               @(negedge clk);
               blk_done = 1'b0;
            end
         end
      end
   end

   // chain_done monitor (R7)
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && chain_done) begin
            done_pulses++;
            check("R7 queue drained at end", {96'd0, exp_txn.size()}, 0);
            check("R7 idle at end", {127'd0, busy}, 0);
         end
      end
   end

   task automatic wait_done(input int target);
      int n = 0;
      while (done_pulses < target && n < 5000) begin
         @(negedge clk);
         n++;
      end
      if (n >= 5000) check("watchdog", 1, 0);
   endtask

   task automatic pulse_start(input logic [31:0] p);
      @(negedge clk);
      start = 1'b1; start_ptr = p;
      @(negedge clk);
      start = 1'b0;
   endtask

   initial begin
      logic [31:0] da [7], db [7], dc [7], dd [7];
      da = '{32'h1000_0000, 32'h2000_0000, 32'h0000_0202, 32'h1000_0001, 32'h0000_0010, 32'hA5, 32'h5A};
      db = '{32'h1100_0000, 32'h2100_0000, 32'h0000_0303, 32'h0800_0002, 32'h0000_0020, 32'hB5, 32'hB6};
      dc = '{32'h1200_0000, 32'h2200_0000, 32'h0000_0001, 32'h0800_0003, 32'h0000_0030, 32'hC5, 32'hC6};
      dd = '{32'h1300_0000, 32'h2300_0000, 32'h0000_0101, 32'h0000_0004, 32'h0000_0040, 32'hD5, 32'hD6};
      put_desc(32'h100, da); put_desc(32'h200, db); put_desc(32'h300, dc); put_desc(32'h400, dd);

      repeat (3) @(negedge clk);
      check("R1 reset outputs", {124'd0, busy, mem_req, blk_load, chain_done}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 idle after reset", {124'd0, busy, mem_req, blk_load, chain_done}, 0);

      // R6 R7: three-block chain, source then destination chaining, zero-address link ends it
      lat = 0;
      expect_block(32'h100, 2'd1, da, 32'h0000_0000);
      expect_block(32'h200, 2'd2, db, 32'h0000_0F05);
      expect_block(32'h300, 2'd3, dc, 32'h0000_1007);
      pulse_start(32'h0000_0101);
      wait_done(1);
      check("R5 write-back in memory", memw[32'h110], 32'h0000_1000);
      check("R5 other words untouched", {memw[32'h100], memw[32'h104], memw[32'h108], memw[32'h10C]},
            {da[0], da[1], da[2], da[3]});

      // R8 R9: no chaining enable, valid-looking link; a start mid-chain is ignored
      lat = 2;
      expect_block(32'h400, 2'd0, dd, 32'h0000_0ABC);
      pulse_start(32'h0000_0400);
      repeat (4) @(negedge clk);
      pulse_start(32'h0000_0202);
      wait_done(2);
      repeat (20) @(negedge clk);
      check("R8 R9 no further access", {127'd0, mem_req}, 0);
      check("R8 R9 scoreboard empty", {64'd0, 32'(exp_txn.size()), 32'(exp_load.size())}, 0);
      check("R7 done pulses", {96'd0, done_pulses}, 2);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule